// File: doc/BRIEF.md
# Serial Control Port for a Telephone Line Front End

This block receives configuration bytes over a three-wire serial write port (enable, serial clock, serial data) and holds them in two 8-bit control registers that steer a telephone line-interface front end. While the enable is high, each rising serial clock edge shifts one data bit into an 8-bit shift register, most significant bit first. When the enable drops, the byte then in the shift register is committed. Its top bit picks the destination register. While the enable is low, the clock and data lines may carry traffic for other devices and the port does not react to them.

The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies. The register contents are decoded into control outputs: a hookswitch drive, two general-purpose logic outputs, a 2-bit DC mask mode, a dialing-mode flag, and the AGC, mute and gain selects. An active-high low-supply reset clears the synchronizers, the shift register and both control registers. After this reset the front end is in voltage regulation with the hookswitch output low.

Top module: `line_iface_ctl`

## Requirements
- R1: While the synchronized enable is high, each synchronized rising edge of the serial clock shifts the synchronized data bit into bit 0 of the shift register, and the older bits move one place toward bit 7. Bytes are therefore sent most significant bit first.
- R2: When the synchronized enable goes from high to low, the 8 bits in the shift register are written to one control register. No control register changes at any other time except under reset.
- R3: Bit 7 of the committed byte selects the destination. A value of 0 writes control register A and a value of 1 writes control register B. The other register keeps its value.
- R4: While the enable is low, serial clock and data activity changes neither the shift register nor any output.
- R5: While supply_low is high, both control registers and the shift register are held at 0. All decoded outputs are then 0 and mask_mode is 2'b00.
- R6: Register A bit 0 drives hook_drv, bit 1 drives gp_out1 and bit 2 drives gp_out2. Each output is high when its bit is 1.
- R7: Register B drives six outputs. Bit 0 drives agc_off, bit 1 drives agc_ratio_hi, bit 2 drives tx_mute, bit 3 drives rx_mute, bit 4 drives tx_boost and bit 5 drives rx_boost.
- R8: Register A bit 5 drives dial_mode. mask_mode is decoded with dialing mode taking priority:
  - 2'b11 when register A bit 5 is 1;
  - otherwise 2'b01 or 2'b10 when register A bit 4 is 1, with 2'b10 chosen when register B bit 1 is 1;
  - otherwise 2'b00 (voltage regulation).
- R9: The shift register is not cleared between enable windows. A window with fewer than eight clock pulses commits the previous contents shifted by the pulses received, and bit 7 of that result picks the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_low | input | 1 | Low-supply reset, active high, asynchronous |
| ser_en | input | 1 | Serial bus enable, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| hook_drv | output | 1 | Hookswitch drive (register A bit 0) |
| gp_out1 | output | 1 | General logic output 1 (register A bit 1) |
| gp_out2 | output | 1 | General logic output 2 (register A bit 2) |
| dial_mode | output | 1 | Low-drop dialing mode (register A bit 5) |
| mask_mode | output | 2 | Decoded DC mask mode |
| agc_off | output | 1 | AGC range disabled |
| agc_ratio_hi | output | 1 | Higher AGC ratio selected |
| tx_mute | output | 1 | Transmit mute |
| rx_mute | output | 1 | Receive mute |
| tx_boost | output | 1 | Transmit +6 dB |
| rx_boost | output | 1 | Receive +6 dB |

## Verification
A serial input change reaches the edge detector after two synchronizer flops. The shift or commit then takes one more system clock edge, so a register update is visible three system clock edges after the enable falls. The outputs decode the registers combinationally and add no further delay.

The bench holds every serial level for at least three system cycles, so each level is seen by the synchronizers. It then waits eight cycles after lowering the enable before it samples. All stimulus changes and all output samples happen on the falling edge of the system clock.

// File: rtl/lic_pkg.sv
package lic_pkg;

  // Bit positions inside control register A
  localparam int unsigned A_HOOK   = 0;
  localparam int unsigned A_OUT1   = 1;
  localparam int unsigned A_OUT2   = 2;
  localparam int unsigned A_CURREG = 4;
  localparam int unsigned A_DIAL   = 5;

  // Bit positions inside control register B
  localparam int unsigned B_AGCOFF  = 0;
  localparam int unsigned B_RATIO   = 1;
  localparam int unsigned B_TXMUTE  = 2;
  localparam int unsigned B_RXMUTE  = 3;
  localparam int unsigned B_TXBOOST = 4;
  localparam int unsigned B_RXBOOST = 5;

  typedef enum logic [1:0] {
    MASK_VOLT   = 2'b00,
    MASK_CUR_LO = 2'b01,
    MASK_CUR_HI = 2'b10,
    MASK_DIAL   = 2'b11
  } mask_t;

  // Dialing wins, then current regulation split by ratio, else voltage.
  function automatic mask_t mask_decode(input logic cur_reg,
                                        input logic dial,
                                        input logic ratio_hi);
    if (dial)
      return MASK_DIAL;
    else if (cur_reg)
      return ratio_hi ? MASK_CUR_HI : MASK_CUR_LO;
    else
      return MASK_VOLT;
  endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      pipe_q <= '0;
    else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++)
        pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/lic_shifter.sv
module lic_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_s,
  input  logic         sclk_s,
  input  logic         dat_s,
  output logic [W-1:0] shift_q,
  output logic         shift_pulse,
  output logic         commit
);

  logic en_d;
  logic sclk_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      en_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
    end
  end

  // A rising serial clock counts only inside an enable window.
  assign shift_pulse = en_s & sclk_s & ~sclk_d;
  // The enable falling edge hands the byte to the register bank.
  assign commit      = en_d & ~en_s;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      shift_q <= '0;
    else if (shift_pulse)
      shift_q <= {shift_q[W-2:0], dat_s};
  end

endmodule

// File: rtl/lic_regbank.sv
module lic_regbank #(
  parameter int unsigned W      = 8,
  parameter int unsigned N_REGS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit,
  input  logic [W-1:0]              byte_i,
  output logic [N_REGS-1:0][W-1:0]  regs_q
);

  localparam int unsigned SEL_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  logic [SEL_W-1:0] sel;
  assign sel = byte_i[W-1 -: SEL_W];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk or posedge rst) begin
      if (rst)
        regs_q[i] <= '0;
      else if (commit && (sel == SEL_W'(i)))
        regs_q[i] <= byte_i;
    end
  end

endmodule

// File: rtl/line_iface_ctl.sv
module line_iface_ctl #(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       supply_low,
  input  logic       ser_en,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic       hook_drv,
  output logic       gp_out1,
  output logic       gp_out2,
  output logic       dial_mode,
  output logic [1:0] mask_mode,
  output logic       agc_off,
  output logic       agc_ratio_hi,
  output logic       tx_mute,
  output logic       rx_mute,
  output logic       tx_boost,
  output logic       rx_boost
);
  import lic_pkg::*;

  localparam int unsigned N_REGS = 2;
  localparam int unsigned N_SYNC = 3;

  logic [N_SYNC-1:0]             sync_w;
  logic                          en_s, sclk_s, dat_s;
  logic [REG_W-1:0]              shift_w;
  logic                          shift_pulse_w;
  logic                          commit_w;
  logic [N_REGS-1:0][REG_W-1:0]  regs_w;
  logic [REG_W-1:0]              reg_a_w, reg_b_w;
  mask_t                         mask_w;

  lic_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (supply_low),
    .async_i ({ser_en, ser_clk, ser_dat}),
    .sync_o  (sync_w)
  );

  assign {en_s, sclk_s, dat_s} = sync_w;

  lic_shifter #(.W(REG_W)) shifter_i (
    .clk         (clk),
    .rst         (supply_low),
    .en_s        (en_s),
    .sclk_s      (sclk_s),
    .dat_s       (dat_s),
    .shift_q     (shift_w),
    .shift_pulse (shift_pulse_w),
    .commit      (commit_w)
  );

  lic_regbank #(.W(REG_W), .N_REGS(N_REGS)) regbank_i (
    .clk    (clk),
    .rst    (supply_low),
    .commit (commit_w),
    .byte_i (shift_w),
    .regs_q (regs_w)
  );

  assign reg_a_w = regs_w[0];
  assign reg_b_w = regs_w[1];

  assign hook_drv     = reg_a_w[A_HOOK];
  assign gp_out1      = reg_a_w[A_OUT1];
  assign gp_out2      = reg_a_w[A_OUT2];
  assign dial_mode    = reg_a_w[A_DIAL];

  assign agc_off      = reg_b_w[B_AGCOFF];
  assign agc_ratio_hi = reg_b_w[B_RATIO];
  assign tx_mute      = reg_b_w[B_TXMUTE];
  assign rx_mute      = reg_b_w[B_RXMUTE];
  assign tx_boost     = reg_b_w[B_TXBOOST];
  assign rx_boost     = reg_b_w[B_RXBOOST];

  assign mask_w    = mask_decode(reg_a_w[A_CURREG], reg_a_w[A_DIAL], reg_b_w[B_RATIO]);
  assign mask_mode = mask_w;

  logic unused_bits;
  assign unused_bits = ^{reg_a_w[REG_W-1:6], reg_a_w[3], reg_b_w[REG_W-1:6]};

endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en_s,
  input logic         shift_pulse,
  input logic         commit,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [1:0]   mask_mode
);
  import lic_pkg::*;

  assert_shift_only_on_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !shift_pulse |=> $stable(shift_q));

  assert_regs_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(reg_a) && $stable(reg_b)));

  assert_load_a_R3: assert property (@(posedge clk) disable iff (rst)
    (commit && !shift_q[W-1]) |=> (reg_a == $past(shift_q) && $stable(reg_b)));

  assert_load_b_R3: assert property (@(posedge clk) disable iff (rst)
    (commit && shift_q[W-1]) |=> (reg_b == $past(shift_q) && $stable(reg_a)));

  assert_idle_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> $stable(shift_q));

  assert_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reg_a == '0 && reg_b == '0 && shift_q == '0));

  assert_dial_priority_R8: assert property (@(posedge clk) disable iff (rst)
    reg_a[A_DIAL] |-> (mask_mode == 2'b11));

  assert_voltage_default_R8: assert property (@(posedge clk) disable iff (rst)
    (!reg_a[A_DIAL] && !reg_a[A_CURREG]) |-> (mask_mode == 2'b00));

endmodule

bind line_iface_ctl lic_checker #(.W(REG_W)) chk_i (
  .clk         (clk),
  .rst         (supply_low),
  .en_s        (en_s),
  .shift_pulse (shift_pulse_w),
  .commit      (commit_w),
  .shift_q     (shift_w),
  .reg_a       (reg_a_w),
  .reg_b       (reg_b_w),
  .mask_mode   (mask_mode)
);

// File: tb/line_iface_ctl_tb.sv
module line_iface_ctl_tb_top;

  logic clk = 1'b0;
  logic supply_low = 1'b1;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic hook_drv, gp_out1, gp_out2, dial_mode;
  logic [1:0] mask_mode;
  logic agc_off, agc_ratio_hi, tx_mute, rx_mute, tx_boost, rx_boost;

  int checks = 0;
  int errors = 0;

  // Bench model of the two registers and the shift register
  logic [7:0] ea = '0, eb = '0, sh = '0;

  always #2 clk = ~clk;

  line_iface_ctl dut_i (
    .clk(clk), .supply_low(supply_low),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .hook_drv(hook_drv), .gp_out1(gp_out1), .gp_out2(gp_out2),
    .dial_mode(dial_mode), .mask_mode(mask_mode),
    .agc_off(agc_off), .agc_ratio_hi(agc_ratio_hi),
    .tx_mute(tx_mute), .rx_mute(rx_mute),
    .tx_boost(tx_boost), .rx_boost(rx_boost)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic check_all(string ctx);
    logic [1:0] m;
    // R8: dialing = 3, current regulation = 1 plus ratio bit, else 0
    m = ea[5] ? 2'd3 : (ea[4] ? 2'(1 + int'(eb[1])) : 2'd0);
    chk({ctx, " R6 hook"},  {7'd0, hook_drv}, {7'd0, ea[0]});
    chk({ctx, " R6 out1"},  {7'd0, gp_out1},  {7'd0, ea[1]});
    chk({ctx, " R6 out2"},  {7'd0, gp_out2},  {7'd0, ea[2]});
    chk({ctx, " R8 dial"},  {7'd0, dial_mode}, {7'd0, ea[5]});
    chk({ctx, " R8 mask"},  {6'd0, mask_mode}, {6'd0, m});
    chk({ctx, " R7 regB"},
        {2'd0, rx_boost, tx_boost, rx_mute, tx_mute, agc_ratio_hi, agc_off},
        {2'd0, eb[5:0]});
  endtask

  task automatic send_bit(logic b);
    ser_dat = b;
    step(3);
    ser_clk = 1'b1;
    step(3);
    ser_clk = 1'b0;
    step(2);
  endtask

  // Opens an enable window, sends the low n bits of v MSB first, closes it.
  task automatic send_window(int n, logic [7:0] v);
    ser_en = 1'b1;
    step(3);
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(v[i]);
      sh = {sh[6:0], v[i]};
    end
    step(2);
    ser_en = 1'b0;
    step(8);
    if (sh[7]) eb = sh; else ea = sh;
  endtask

  initial begin
    step(3);
    check_all("R5 reset");
    supply_low = 1'b0;
    step(3);
    check_all("R5 after release");

    // Sweep register A with both ratio settings in register B (R1 R2 R3 R6 R8)
    for (int r = 0; r < 2; r++) begin
      send_window(8, 8'h80 | 8'(r << 1));
      check_all("R3 to B");
      for (int a = 0; a < 64; a++) begin
        send_window(8, 8'(a));
        check_all("R1 R2 sweep A");
      end
    end

    // Sweep register B with current regulation selected in A (R7 R8)
    send_window(8, 8'h10);
    for (int b = 0; b < 64; b++) begin
      send_window(8, 8'h80 | 8'(b));
      check_all("R3 sweep B");
    end

    // R4: clock and data activity with enable low is ignored
    send_window(8, 8'h07);
    check_all("R4 setup");
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    step(6);
    check_all("R4 idle traffic");
    send_window(0, 8'h00);
    check_all("R4 empty window");

    // R9: short window shifts the retained contents
    send_window(8, 8'h13);
    send_window(3, 8'h05);
    check_all("R9 short window to B");
    send_window(2, 8'h00);
    check_all("R9 short window to A");

    // R5: mid-run low-supply reset clears everything
    send_window(8, 8'h37);
    send_window(8, 8'hBF);
    check_all("R5 preload");
    supply_low = 1'b1;
    step(2);
    ea = '0; eb = '0; sh = '0;
    check_all("R5 mid-run");
    supply_low = 1'b0;
    step(3);
    check_all("R5 release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule